// File: doc/BRIEF.md
# Audio Control Register Slave (two-wire write port)

This block is the control-port receiver of an audio processor. It listens to a two-wire serial bus (I2C, write transfers only), accepts transfers aimed at its fixed device address, and loads eight 8-bit control registers. The registers hold the settings for volume/loudness, four per-output fader attenuators, bass, treble and a switch register. The switch register also carries a general-mute flag.

A transfer has a fixed order: START, the address byte, a pointer byte, one or more data bytes, then STOP. The slave drives the acknowledge after each byte that it accepts. The low three bits of the pointer byte choose the first register. Each further data byte goes to the next register, and the pointer wraps from the last register back to the first.

All register contents leave the block in parallel on one flat bus. Each write also gives a one-cycle strobe that carries the register index and the data byte. Downstream logic can use the strobe to react to single updates.

Top module: `audio_ctl_i2c_slave`

## Requirements
- R1: After reset every register reads 0, except bit 1 of register 7 (the switch register), which reads 1. After reset the SDA driver is released (`sda_oe`=0) and `wr_stb` is 0.
- R2: The address byte 8'h80 is acknowledged. The slave holds SDA low through the ninth SCL high phase.
- R3: Any other address byte is not acknowledged, including 8'h81 (the read direction). After such a byte, all bytes are ignored and no register changes until the next START or STOP.
- R4: The byte after the address is acknowledged. Its bits [2:0] select the register for the first data byte, and its bits [7:3] have no effect.
- R5: Each data byte is acknowledged and stored in the selected register. The write produces `wr_stb` high for exactly one clock, with `wr_addr` equal to the register index and `wr_data` equal to the byte.
- R6: After each data byte the register index increments by one, and it wraps from 7 to 0.
- R7: A repeated START at any point ends the current transfer, and a partly received data byte is discarded. Address matching then starts again.
- R8: After STOP the slave ignores SCL activity until a START. Bytes clocked without a START are neither acknowledged nor written.
- R9: Register contents change only on a cycle that follows a `wr_stb` pulse.
- R10: The slave changes `sda_oe` only while SCL is low, or on a START or STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line, asynchronous |
| sda_i | input | 1 | Serial data line level, asynchronous |
| sda_oe | output | 1 | 1 pulls SDA low (acknowledge) |
| reg_flat | output | NUM_REGS*8 | All registers; register i is at bits [8i+7:8i] |
| wr_stb | output | 1 | One-cycle pulse per stored data byte |
| wr_addr | output | 3 | Register index of the current write |
| wr_data | output | 8 | Data byte of the current write |

## Verification
The bench uses the default configuration: eight registers, a two-stage synchroniser and the mute flag at bit 1. With eight registers, one burst of nine data bytes from each of the eight start indices sweeps every pointer value and every wrap position. The sweeps run with both clean and upper-bit-polluted pointer bytes. Further cases cover a set of wrong addresses, including the read direction, a START that cuts a data byte in half, and bus clocking after STOP. For each case the expected register image and acknowledge pattern are rebuilt arithmetically in the bench.

// File: rtl/audio_ctl_pkg.sv
// Shared constants and the receiver state type for the audio control slave.
package audio_ctl_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_SUB,
        ST_DATA,
        ST_SKIP
    } rx_state_t;
endpackage

// File: rtl/i2c_line_sync.sv
// Synchronises SCL and SDA into clk and flags SCL edges and bus conditions.
// Assumes both lines idle high; reset preloads the synchroniser with 1.
module i2c_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);
    logic [SYNC_STAGES-1:0] scl_sh;
    logic [SYNC_STAGES-1:0] sda_sh;
    logic                   scl_prev;
    logic                   sda_prev;

    // Shift both lines through the synchroniser and keep one delayed copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_sh   <= '1;
            sda_sh   <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_sh   <= {scl_sh[SYNC_STAGES-2:0], scl_i};
            sda_sh   <= {sda_sh[SYNC_STAGES-2:0], sda_i};
            scl_prev <= scl_sh[SYNC_STAGES-1];
            sda_prev <= sda_sh[SYNC_STAGES-1];
        end
    end

    // Decode edges and START/STOP from the synchronised levels.
    always_comb begin
        scl_lvl   = scl_sh[SYNC_STAGES-1];
        sda_lvl   = sda_sh[SYNC_STAGES-1];
        scl_rise  = scl_lvl & ~scl_prev;
        scl_fall  = ~scl_lvl & scl_prev;
        bus_start = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
        bus_stop  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
    end
endmodule

// File: rtl/i2c_byte_engine.sv
// Byte-level protocol engine: address match, pointer byte, data bytes with
// wrapping auto-increment, acknowledge drive and the write strobe.
// Assumes edge/condition pulses from i2c_line_sync, one clock wide.
module i2c_byte_engine
    import audio_ctl_pkg::*;
#(
    parameter int             NUM_REGS = 8,
    parameter logic [BYTE_W-1:0] DEV_ADDR = 8'h80,
    localparam int            PTR_W    = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              bus_start,
    input  logic              bus_stop,
    output logic              sda_oe,
    output logic              wr_stb,
    output logic [PTR_W-1:0]  wr_addr,
    output logic [BYTE_W-1:0] wr_data
);
    localparam int          CNT_W    = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_W);

    rx_state_t          state;
    logic [BYTE_W-1:0]  shreg;
    logic [CNT_W-1:0]   bit_cnt;
    logic               in_ack;
    logic [PTR_W-1:0]   ptr;
    logic               active;

    // Engine participates in the bus only inside an addressed transfer.
    always_comb active = (state == ST_ADDR) || (state == ST_SUB) || (state == ST_DATA);

    // Receive bits, decide acknowledges and issue register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            shreg   <= '0;
            bit_cnt <= '0;
            in_ack  <= 1'b0;
            ptr     <= '0;
            sda_oe  <= 1'b0;
            wr_stb  <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_stb <= 1'b0;
            if (bus_start) begin
                state   <= ST_ADDR;
                bit_cnt <= '0;
                in_ack  <= 1'b0;
                sda_oe  <= 1'b0;
            end else if (bus_stop) begin
                state   <= ST_IDLE;
                bit_cnt <= '0;
                in_ack  <= 1'b0;
                sda_oe  <= 1'b0;
            end else if (active) begin
                if (scl_rise && !in_ack && bit_cnt < FULL_CNT) begin
                    shreg   <= {shreg[BYTE_W-2:0], sda_lvl};
                    bit_cnt <= bit_cnt + CNT_W'(1);
                end else if (scl_fall) begin
                    if (in_ack) begin
                        in_ack  <= 1'b0;
                        sda_oe  <= 1'b0;
                        bit_cnt <= '0;
                        if (state == ST_ADDR)     state <= ST_SUB;
                        else if (state == ST_SUB) state <= ST_DATA;
                    end else if (bit_cnt == FULL_CNT) begin
                        unique case (state)
                            ST_ADDR: begin
                                if (shreg == DEV_ADDR) begin
                                    sda_oe <= 1'b1;
                                    in_ack <= 1'b1;
                                end else begin
                                    state <= ST_SKIP;
                                end
                            end
                            ST_SUB: begin
                                ptr    <= shreg[PTR_W-1:0];
                                sda_oe <= 1'b1;
                                in_ack <= 1'b1;
                            end
                            default: begin
                                wr_stb  <= 1'b1;
                                wr_addr <= ptr;
                                wr_data <= shreg;
                                ptr     <= ptr + PTR_W'(1);
                                sda_oe  <= 1'b1;
                                in_ack  <= 1'b1;
                            end
                        endcase
                    end
                end
            end
        end
    end
endmodule

// File: rtl/ctl_reg_bank.sv
// Bank of NUM_REGS byte registers written by a strobe, read out in parallel.
// Reset value is 0 except the general-mute bit of the last (switch) register.
module ctl_reg_bank
    import audio_ctl_pkg::*;
#(
    parameter int  NUM_REGS = 8,
    parameter int  MUTE_BIT = 1,
    localparam int PTR_W    = $clog2(NUM_REGS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_stb,
    input  logic [PTR_W-1:0]           wr_addr,
    input  logic [BYTE_W-1:0]          wr_data,
    output logic [NUM_REGS*BYTE_W-1:0] reg_flat
);
    localparam int SWITCH_IDX = NUM_REGS - 1;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        localparam logic [BYTE_W-1:0] RST_VAL =
            (g == SWITCH_IDX) ? (BYTE_W'(1) << MUTE_BIT) : '0;
        logic [BYTE_W-1:0] q;

        // Hold one register; load it when the strobe addresses it.
        always_ff @(posedge clk) begin
            if (!rst_n)                                 q <= RST_VAL;
            else if (wr_stb && wr_addr == PTR_W'(g))    q <= wr_data;
        end

        assign reg_flat[g*BYTE_W +: BYTE_W] = q;
    end
endmodule

// File: rtl/audio_ctl_i2c_slave.sv
// Top: two-wire write-only slave feeding the audio control register bank.
// Assumes an external open-drain pad: sda_oe=1 pulls SDA low.
module audio_ctl_i2c_slave
    import audio_ctl_pkg::*;
#(
    parameter int             NUM_REGS    = 8,
    parameter int             SYNC_STAGES = 2,
    parameter int             MUTE_BIT    = 1,
    parameter logic [BYTE_W-1:0] DEV_ADDR = 8'h80,
    localparam int            PTR_W       = $clog2(NUM_REGS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       scl_i,
    input  logic                       sda_i,
    output logic                       sda_oe,
    output logic [NUM_REGS*BYTE_W-1:0] reg_flat,
    output logic                       wr_stb,
    output logic [PTR_W-1:0]           wr_addr,
    output logic [BYTE_W-1:0]          wr_data
);
    logic scl_lvl, sda_lvl, scl_rise, scl_fall, bus_start, bus_stop;

    i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) i_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .bus_start (bus_start),
        .bus_stop  (bus_stop)
    );

    i2c_byte_engine #(.NUM_REGS(NUM_REGS), .DEV_ADDR(DEV_ADDR)) i_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .bus_start (bus_start),
        .bus_stop  (bus_stop),
        .sda_oe    (sda_oe),
        .wr_stb    (wr_stb),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data)
    );

    ctl_reg_bank #(.NUM_REGS(NUM_REGS), .MUTE_BIT(MUTE_BIT)) i_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_stb   (wr_stb),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .reg_flat (reg_flat)
    );
endmodule

// File: rtl/audio_ctl_i2c_chk.sv
// Protocol and register-bank checker, bound into audio_ctl_i2c_slave.
module audio_ctl_i2c_chk #(
    parameter int  NUM_REGS = 8,
    localparam int PTR_W    = $clog2(NUM_REGS)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  scl_lvl,
    input logic                  bus_start,
    input logic                  bus_stop,
    input logic                  sda_oe,
    input logic                  wr_stb,
    input logic [PTR_W-1:0]      wr_addr,
    input logic [7:0]            wr_data,
    input logic [NUM_REGS*8-1:0] reg_flat
);
    logic [PTR_W-1:0] last_addr;
    logic [7:0]       last_data;

    // Remember the most recent write for the landing check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_addr <= '0;
            last_data <= '0;
        end else if (wr_stb) begin
            last_addr <= wr_addr;
            last_data <= wr_data;
        end
    end

    AST_STB_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb); // R5

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_stb) |-> reg_flat[last_addr*8 +: 8] == last_data); // R5

    AST_STB_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> sda_oe); // R5

    AST_REGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> $stable(reg_flat)); // R9

    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_lvl && $past(scl_lvl) && !bus_start && !bus_stop) |-> $stable(sda_oe)); // R10

    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_stop |=> !sda_oe); // R8
endmodule

bind audio_ctl_i2c_slave audio_ctl_i2c_chk #(.NUM_REGS(NUM_REGS)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_lvl   (scl_lvl),
    .bus_start (bus_start),
    .bus_stop  (bus_stop),
    .sda_oe    (sda_oe),
    .wr_stb    (wr_stb),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .reg_flat  (reg_flat)
);

// File: tb/test_audio_ctl_i2c_slave.sv
// Bench: bus master model with wired-AND SDA; expected images computed here.
module test_audio_ctl_i2c_slave;
    localparam int N  = 8;
    localparam int QC = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_line;
    logic sda_oe, wr_stb;
    logic [N*8-1:0] reg_flat;
    logic [2:0] wr_addr;
    logic [7:0] wr_data;

    int checks = 0;
    int errs = 0;
    int stb_count = 0;
    bit stb_wide = 0;
    bit prev_stb = 0;
    logic [2:0] last_a;
    logic [7:0] last_d;
    logic [7:0] expv [N];

    always #4 clk = ~clk;
    assign sda_line = sda_m & ~sda_oe;

    audio_ctl_i2c_slave i_audio_ctl_i2c_slave (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe(sda_oe), .reg_flat(reg_flat), .wr_stb(wr_stb),
        .wr_addr(wr_addr), .wr_data(wr_data)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_stb) begin
                stb_count++;
                last_a = wr_addr;
                last_d = wr_data;
            end
            if (wr_stb && prev_stb) stb_wide = 1;
            prev_stb = wr_stb;
        end
    end

    task automatic chk(input string req, input longint act, input longint exp_v);
        checks++;
        if (act !== exp_v) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
        end
    endtask

    task automatic qwait();
        repeat (QC) @(posedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; qwait(); scl_m = 1'b1; qwait();
        sda_m = 1'b0; qwait(); scl_m = 1'b0; qwait();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; qwait(); scl_m = 1'b1; qwait();
        sda_m = 1'b1; qwait();
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; qwait(); scl_m = 1'b1; qwait(); qwait(); scl_m = 1'b0; qwait();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; qwait(); scl_m = 1'b1; qwait();
        @(negedge clk); ack = ~sda_line;
        qwait(); scl_m = 1'b0; qwait();
    endtask

    function automatic logic [N*8-1:0] image();
        logic [N*8-1:0] v;
        for (int i = 0; i < N; i++) v[i*8 +: 8] = expv[i];
        return v;
    endfunction

    task automatic burst(input int sa, input logic [7:0] sub_byte);
        logic ack;
        int s0;
        logic [7:0] d;
        bit all_ack;
        s0 = stb_count;
        all_ack = 1;
        bus_start();
        send_byte(8'h80, ack); chk("R2 address ack", ack, 1);
        send_byte(sub_byte, ack); chk("R4 pointer ack", ack, 1);
        for (int k = 0; k < 9; k++) begin
            d = 8'((sa * 37 + k * 11 + 5 + sub_byte) & 255);
            send_byte(d, ack);
            if (!ack) all_ack = 0;
            expv[(sa + k) % N] = d;
        end
        bus_stop();
        @(negedge clk);
        chk("R5 data acks", all_ack, 1);
        chk("R6 wrapped register image", reg_flat, image());
        chk("R5 strobe count", stb_count - s0, 9);
        chk("R5 last strobe addr", last_a, sa);
        chk("R5 last strobe data", last_d, expv[sa]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, errs);
        $finish;
    end

    initial begin
        logic ack;
        logic [7:0] bad [4] = '{8'h81, 8'h82, 8'h00, 8'hC0};
        int s0;
        for (int i = 0; i < N; i++) expv[i] = 8'h00;
        expv[N-1] = 8'h02;
        repeat (5) @(posedge clk);
        rst_n = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset image", reg_flat, image());
        chk("R1 sda released", sda_oe, 0);
        chk("R1 no strobe", wr_stb, 0);

        for (int sa = 0; sa < N; sa++) burst(sa, 8'(sa));
        for (int sa = 0; sa < N; sa++) burst(sa, 8'(8'hF8 | sa));
        chk("R5 strobe width", stb_wide, 0);

        // R3 wrong addresses, then bytes that must be ignored
        foreach (bad[j]) begin
            s0 = stb_count;
            bus_start();
            send_byte(bad[j], ack); chk("R3 no address ack", ack, 0);
            send_byte(8'h02, ack);  chk("R3 ignored byte no ack", ack, 0);
            send_byte(8'h5A, ack);  chk("R3 ignored byte no ack", ack, 0);
            bus_stop();
            @(negedge clk);
            chk("R3 registers unchanged", reg_flat, image());
            chk("R3 no strobe", stb_count - s0, 0);
        end

        // R7 repeated START in the middle of a data byte
        bus_start();
        send_byte(8'h80, ack);
        send_byte(8'h03, ack);
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        bus_start();
        send_byte(8'h80, ack); chk("R7 address ack after restart", ack, 1);
        send_byte(8'h05, ack);
        send_byte(8'hC3, ack); chk("R7 data ack after restart", ack, 1);
        expv[5] = 8'hC3;
        bus_stop();
        @(negedge clk);
        chk("R7 partial byte dropped, new write landed", reg_flat, image());

        // R8 clocking after STOP without START
        s0 = stb_count;
        send_byte(8'h80, ack); chk("R8 no ack without start", ack, 0);
        send_byte(8'h01, ack); chk("R8 no ack without start", ack, 0);
        send_byte(8'hEE, ack);
        @(negedge clk);
        chk("R8 registers unchanged", reg_flat, image());
        chk("R9 no strobe outside transfer", stb_count - s0, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
        $finish;
    end
endmodule